// File: doc/BRIEF.md
# Ternary Multiplexer Logic Unit

This block is a purely combinational ternary logic cell. Every three-valued signal (a trit) travels on a two-bit binary code. The cell contains a forward three-way multiplexer and a reverse-order one, both steered by a three-valued control trit. It also has a ternary inverter, and two example functions (one of one argument, one of two) that are built as trees of forward multiplexer instances. A three-bit operation code picks which of these five results drives the output trit.

The control trit `sel` steers both multiplexers. It is also the argument of the inverter and of the one-argument function, and it is the first argument of the two-argument function. Data trit `d1` is the second argument of that function. An error flag marks any illegal trit code on an input and any unused operation code. While the flag is set, the output is forced to the code for 0.

Top module: `tmux_unit`

## Requirements
- R1: Trit codes are 2'b00 = 0, 2'b01 = 1 and 2'b10 = 2. With `op` = 3'd0 (forward mux), `y` equals `d1`, `d2` or `d3` when `sel` is 0, 1 or 2 respectively.
- R2: With `op` = 3'd1 (reverse mux), `y` equals `d3`, `d2` or `d1` when `sel` is 0, 1 or 2 respectively.
- R3: With `op` = 3'd2 (inverter), `y` = 2 − `sel`, so 0→2, 1→1 and 2→0.
- R4: With `op` = 3'd3 (one-argument function of `sel`), `y` is 0, 2 or 1 for `sel` = 0, 1 or 2.
- R5: With `op` = 3'd4 (two-argument function, x0 = `sel`, x1 = `d1`), `y` for x0 = 0, 1, 2 is 2, 1, 0 when x1 = 0; it is 0, 1, 2 when x1 = 1; and it is 1, 0, 2 when x1 = 2.
- R6: A forward mux whose data are (0,1,2) outputs `sel`. One whose data are (2,1,0) outputs 2 − `sel`. One whose three data are the same constant outputs that constant.
- R7: `err` is 1 when any of `sel`, `d1`, `d2`, `d3` carries the code 2'b11, whatever the operation, or when `op` is 3'd5, 3'd6 or 3'd7. While `err` is 1, `y` is 2'b00. Otherwise `err` is 0.
- R8: `y` never carries the code 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op   | input  | 3 | Operation code: 0 forward mux, 1 reverse mux, 2 inverter, 3 one-argument function, 4 two-argument function |
| sel  | input  | 2 | Control trit / first argument |
| d1   | input  | 2 | Data trit 1 / second argument of the two-argument function |
| d2   | input  | 2 | Data trit 2 |
| d3   | input  | 2 | Data trit 3 |
| y    | output | 2 | Result trit |
| err  | output | 1 | Illegal input code or operation |

## Verification
The bench sweeps every operation code against every code on all four trit inputs, including 2'b11. This catches a reverse mux that is wired in forward order, because its `sel` = 0 and `sel` = 2 results would come out swapped. It also catches a function tree whose row for one x1 value is permuted, because only that row of the two-argument table would be wrong. Illegal codes on an input that the chosen operation does not read are included on purpose: a design that checks only the inputs it uses would leave `err` low there. The mux identities are driven as named cases, so a mux that passes one data input through wrongly shows up as a broken identity rather than as a scattered mismatch.

// File: rtl/tmux_pkg.sv
// Shared trit encoding and operation codes for the ternary multiplexer unit.
// Assumes one trit per TRIT_W-bit binary code, with one code left illegal.
package tmux_pkg;
    localparam int TRIT_W = 2;
    localparam int OP_W   = 3;
    localparam int N_TRIT_IN = 4;

    typedef logic [TRIT_W-1:0] trit_t;

    localparam trit_t T0   = 2'd0;
    localparam trit_t T1   = 2'd1;
    localparam trit_t T2   = 2'd2;
    localparam trit_t TBAD = 2'd3;

    typedef enum logic [OP_W-1:0] {
        OP_FWD = 3'd0,
        OP_REV = 3'd1,
        OP_INV = 3'd2,
        OP_FN1 = 3'd3,
        OP_FN2 = 3'd4
    } op_e;

    // True when a trit code is one of the three legal values.
    function automatic logic trit_ok(input trit_t t);
        return t != TBAD;
    endfunction
endpackage

// File: rtl/tmux_fwd.sv
// Forward elementary ternary multiplexer: control 0/1/2 selects d0/d1/d2.
// Assumes the caller flags an illegal control code; in that case it outputs T0.
module tmux_fwd
    import tmux_pkg::*;
(
    input  trit_t ctrl,
    input  trit_t d0,
    input  trit_t d1,
    input  trit_t d2,
    output trit_t y
);
    // Route one data trit according to the control trit.
    always_comb begin : pick
        case (ctrl)
            T0:      y = d0;
            T1:      y = d1;
            T2:      y = d2;
            default: y = T0;
        endcase
        if (!$isunknown({ctrl, d0, d1, d2}) && trit_ok(ctrl) && d0 == d1 && d1 == d2) begin
            AST_FWD_CONST: assert (y == d0) else $error("constant-data mux gave %0d", y); // R6
        end
    end
endmodule

// File: rtl/tmux_rev.sv
// Reverse elementary ternary multiplexer: control 0/1/2 selects d2/d1/d0.
// Built from one forward mux with its data order reversed.
module tmux_rev
    import tmux_pkg::*;
(
    input  trit_t ctrl,
    input  trit_t d0,
    input  trit_t d1,
    input  trit_t d2,
    output trit_t y
);
    trit_t y_int;

    tmux_fwd u_fwd (
        .ctrl (ctrl),
        .d0   (d2),
        .d1   (d1),
        .d2   (d0),
        .y    (y_int)
    );

    // Pass the forward result out and check the middle leg is unaffected.
    always_comb begin : drive
        y = y_int;
        if (!$isunknown({ctrl, d1}) && ctrl == T1) begin
            AST_REV_MID: assert (y == d1) else $error("reverse mux middle leg wrong"); // R2
        end
    end
endmodule

// File: rtl/tmux_inv.sv
// Ternary inverter: output is 2 minus the input. Illegal input gives T0.
module tmux_inv
    import tmux_pkg::*;
(
    input  trit_t x,
    output trit_t y
);
    // Subtract from the top value for legal codes.
    always_comb begin : invert
        y = trit_ok(x) ? trit_t'(T2 - x) : T0;
        if (!$isunknown(x) && trit_ok(x)) begin
            AST_INV_SUM: assert (32'(x) + 32'(y) == 32'd2) else $error("inverter sum wrong"); // R3
        end
    end
endmodule

// File: rtl/tmux_fn1.sv
// One-argument example function (0->0, 1->2, 2->1) as a single forward mux
// with constant data inputs.
module tmux_fn1
    import tmux_pkg::*;
(
    input  trit_t x,
    output trit_t y
);
    trit_t y_int;

    tmux_fwd u_mux (
        .ctrl (x),
        .d0   (T0),
        .d1   (T2),
        .d2   (T1),
        .y    (y_int)
    );

    // Forward the tree output and check that zero maps only to zero.
    always_comb begin : drive
        y = y_int;
        if (!$isunknown(x) && trit_ok(x)) begin
            AST_FN1_ZERO: assert ((x == T0) == (y == T0)) else $error("fn1 zero map wrong"); // R4
        end
    end
endmodule

// File: rtl/tmux_fn2.sv
// Two-argument example function as a two-tier tree of forward muxes:
// tier one builds one row per x1 value, steered by x0; tier two picks the row by x1.
module tmux_fn2
    import tmux_pkg::*;
(
    input  trit_t x0,
    input  trit_t x1,
    output trit_t y
);
    localparam int N_ROW = 3;

    // Row constants: entry [r][c] is f(x0 = c, x1 = r).
    localparam trit_t ROW_TAB [N_ROW][N_ROW] = '{
        '{T2, T1, T0},
        '{T0, T1, T2},
        '{T1, T0, T2}
    };

    trit_t row_y [N_ROW];
    trit_t y_int;

    for (genvar r = 0; r < N_ROW; r++) begin : g_row
        tmux_fwd u_row (
            .ctrl (x0),
            .d0   (ROW_TAB[r][0]),
            .d1   (ROW_TAB[r][1]),
            .d2   (ROW_TAB[r][2]),
            .y    (row_y[r])
        );
    end

    tmux_fwd u_col (
        .ctrl (x1),
        .d0   (row_y[0]),
        .d1   (row_y[1]),
        .d2   (row_y[2]),
        .y    (y_int)
    );

    // Forward the tree output and check the identity row.
    always_comb begin : drive
        y = y_int;
        if (!$isunknown({x0, x1}) && trit_ok(x0) && x1 == T1) begin
            AST_FN2_ROW1: assert (y == x0) else $error("fn2 identity row wrong"); // R5
        end
    end
endmodule

// File: rtl/tmux_unit.sv
// Ternary multiplexer logic unit: computes forward mux, reverse mux, inverter
// and two example functions in parallel and selects one by operation code.
// Assumes all inputs are static codes; purely combinational, no clock.
module tmux_unit
    import tmux_pkg::*;
(
    input  logic [OP_W-1:0]   op,
    input  logic [TRIT_W-1:0] sel,
    input  logic [TRIT_W-1:0] d1,
    input  logic [TRIT_W-1:0] d2,
    input  logic [TRIT_W-1:0] d3,
    output logic [TRIT_W-1:0] y,
    output logic              err
);
    trit_t fwd_y, rev_y, inv_y, fn1_y, fn2_y;
    trit_t trit_in [N_TRIT_IN];
    logic [N_TRIT_IN-1:0] bad_in;
    logic  op_bad;
    trit_t pick_y;

    assign trit_in[0] = sel;
    assign trit_in[1] = d1;
    assign trit_in[2] = d2;
    assign trit_in[3] = d3;

    for (genvar i = 0; i < N_TRIT_IN; i++) begin : g_chk
        assign bad_in[i] = !trit_ok(trit_in[i]);
    end

    tmux_fwd u_fwd (.ctrl(sel), .d0(d1), .d1(d2), .d2(d3), .y(fwd_y));
    tmux_rev u_rev (.ctrl(sel), .d0(d1), .d1(d2), .d2(d3), .y(rev_y));
    tmux_inv u_inv (.x(sel), .y(inv_y));
    tmux_fn1 u_fn1 (.x(sel), .y(fn1_y));
    tmux_fn2 u_fn2 (.x0(sel), .x1(d1), .y(fn2_y));

    // Choose the requested result and flag unused operation codes.
    always_comb begin : select_op
        op_bad = 1'b0;
        case (op)
            OP_FWD:  pick_y = fwd_y;
            OP_REV:  pick_y = rev_y;
            OP_INV:  pick_y = inv_y;
            OP_FN1:  pick_y = fn1_y;
            OP_FN2:  pick_y = fn2_y;
            default: begin
                pick_y = T0;
                op_bad = 1'b1;
            end
        endcase
    end

    // Raise the error flag and force the output to zero on any illegal code.
    always_comb begin : out_stage
        err = op_bad || (|bad_in);
        y   = err ? T0 : pick_y;
        if (!$isunknown({op, sel, d1, d2, d3})) begin
            AST_ERR_ZERO: assert (!err || y == T0) else $error("output not zero on error"); // R7
            AST_Y_LEGAL: assert (y != TBAD) else $error("illegal output code"); // R8
            AST_BAD_SEL_ERR: assert (sel != TBAD || err) else $error("bad sel not flagged"); // R7
        end
    end
endmodule

// File: tb/tmux_unit_tb_top.sv
// Exhaustive bench: every operation code against every code on the four trits.
module tmux_unit_tb_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] op = '0;
    logic [1:0] sel = '0, d1 = '0, d2 = '0, d3 = '0;
    logic [1:0] y;
    logic       err;
    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #5 clk = ~clk;

    tmux_unit dut_i (.op(op), .sel(sel), .d1(d1), .d2(d2), .d3(d3), .y(y), .err(err));

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s op=%0d sel=%0d d=%0d,%0d,%0d actual=%0d expected=%0d",
                     req, op, sel, d1, d2, d3, act, exp);
        end
    endtask

    task automatic apply(input int o, input int s, input int a, input int b, input int c);
        @(negedge clk);
        op = 3'(o); sel = 2'(s); d1 = 2'(a); d2 = 2'(b); d3 = 2'(c);
        #1;
    endtask

    // Expected value from the requirement tables, arithmetically.
    function automatic int exp_y(int o, int s, int a, int b, int c);
        if (s == 3 || a == 3 || b == 3 || c == 3 || o > 4) return 0;
        case (o)
            0: return (s == 0) ? a : (s == 1) ? b : c;
            1: return (s == 0) ? c : (s == 1) ? b : a;
            2: return 2 - s;
            3: return (2 * s) % 3;
            default: return (a == 0) ? 2 - s : (a == 1) ? s : (2 * s + 1) % 3;
        endcase
    endfunction

    function automatic string tag(int o);
        case (o)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            default: return "R7";
        endcase
    endfunction

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : main
        int e, bad;
        repeat (2) @(posedge clk);
        rst_n = 1'b1;
        // Reset-like idle state: all zero inputs, forward mux selects d1 = 0. R1 R7
        apply(0, 0, 0, 0, 0);
        check("R1 idle y", int'(y), 0);
        check("R7 idle err", int'(err), 0);

        // Exhaustive sweep. R1 R2 R3 R4 R5 R7 R8
        for (int o = 0; o < 8; o++)
            for (int s = 0; s < 4; s++)
                for (int a = 0; a < 4; a++)
                    for (int b = 0; b < 4; b++)
                        for (int c = 0; c < 4; c++) begin
                            apply(o, s, a, b, c);
                            e = exp_y(o, s, a, b, c);
                            bad = (s == 3 || a == 3 || b == 3 || c == 3 || o > 4) ? 1 : 0;
                            check(tag(o), int'(y), e);
                            check("R7 err", int'(err), bad);
                            check("R8 legal", (y == 2'b11) ? 1 : 0, 0);
                        end

        // Mux identities on the forward mux. R6
        for (int s = 0; s < 3; s++) begin
            apply(0, s, 0, 1, 2);
            check("R6 ident", int'(y), s);
            apply(0, s, 2, 1, 0);
            check("R6 inv", int'(y), 2 - s);
            for (int k = 0; k < 3; k++) begin
                apply(0, s, k, k, k);
                check("R6 const", int'(y), k);
            end
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule